// File: doc/BRIEF.md
# Programmable Countdown Timer with Clock Divider

This block is a 32-bit down-counter that raises a single-cycle event carrying an 8-bit interrupt vector. Software-style write strobes load three registers that share one write-data bus: an initial count, a divide configuration and a timer entry. The timer entry holds the vector, a mask bit and a periodic-mode bit. The counter advances on ticks from a free-running prescaler. The prescaler divides the input clock by a power of two chosen by a non-contiguous 3-bit code.

In one-shot mode the count falls to zero and stays there. The event fires on the tick after zero is reached, so it comes initial+1 ticks after the load. In periodic mode the count reloads from the initial value on the tick after it reaches zero and fires an event there, which gives a period of initial+1 ticks. The current count and the stored configuration are always visible on the outputs. A surrounding interrupt controller takes `event_o` together with `vector_o`.

Top module: `tick_timer`

## Requirements
- R1: A divide-configuration write keeps only bits 3, 1 and 0 of the data. The other bits read back as zero on `div_cfg_o`.
- R2: The divide code is {bit3, bit1, bit0}. The shift is (code+1) mod 8, and a tick occurs every 2^shift clocks, so code 7 divides by 1. An initial-count write clears the prescaler, so the first tick after a load lands 2^shift clocks after the write edge.
- R3: The timer entry keeps the vector in bits 7:0, the mask in bit 16 and the periodic flag in bit 17. `entry_o` shows those bits and zero elsewhere.
- R4: An initial-count write puts the written value on `cur_count_o` one clock after the write and restarts counting from there.
- R5: In one-shot mode (bit 17 = 0) each tick decrements a non-zero count, and the count then holds at 0. Exactly one event fires, on the tick taken at count 0. A load of 0 never fires.
- R6: In periodic mode (bit 17 = 1) the tick taken at count 0 reloads the initial count and fires an event, giving one event per initial+1 ticks. An initial count of 0 fires nothing and the count stays 0.
- R7: While bit 16 is set no event is produced and counting continues. A one-shot expiry that passes while masked is used up and does not fire after unmasking.
- R8: A timer-entry write while the count is 0 cancels a pending one-shot event.
- R9: After reset the entry reads 0x00010000 (masked), the count reads 0, the divide configuration reads 0 (divide by 2) and there is no event.
- R10: `event_o` is high for one clock per expiry, and `vector_o` presents the entry's vector.
- R11: An initial-count write in the same clock as a tick wins. No event is produced for that tick and the new value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Write strobe for the divide configuration |
| entry_we_i | input | 1 | Write strobe for the timer entry |
| init_we_i | input | 1 | Write strobe for the initial count |
| wdata_i | input | 32 | Write data shared by all strobes |
| div_cfg_o | output | 32 | Stored divide configuration |
| entry_o | output | 32 | Stored timer entry |
| cur_count_o | output | 32 | Current count |
| event_o | output | 1 | Single-cycle expiry pulse |
| vector_o | output | 8 | Vector attached to the event |

## Verification
The bench targets the edges of the count. A one-shot load of zero must stay silent, and an off-by-one in the expiry would fire on reaching zero instead of one tick later. A periodic load must give one event per initial+1 ticks, and a wrong reload would change the event count in a fixed window. The bench also covers the non-contiguous divide code: a design that used bits 2:0 would tick at the wrong rate. It places an initial-count write exactly on a tick, where the wrong priority produces a stray event. It also checks that an entry rewrite or a masked expiry does not leave a stale one-shot to fire later.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned SHIFT_W  = 3;
  localparam int unsigned MASK_BIT = 16;
  localparam int unsigned PER_BIT  = 17;
  localparam int unsigned DIV_W    = 4;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vec;
  } entry_t;

  // divide code is {cfg[3], cfg[1:0]}; shift wraps at 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                div_we_i,
  input  logic                entry_we_i,
  input  logic                init_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DIV_W-1:0]    div_cfg_o,
  output entry_t              entry_o,
  output logic [CNT_W-1:0]    init_o,
  output logic [SHIFT_W-1:0]  shift_o
);
  logic [DIV_W-1:0] div_q;
  entry_t           entry_q;
  logic [CNT_W-1:0] init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q            <= '0;
      entry_q.periodic <= 1'b0;
      entry_q.masked   <= 1'b1;
      entry_q.vec      <= '0;
      init_q           <= '0;
    end else begin
      if (div_we_i)   div_q <= {wdata_i[3], 1'b0, wdata_i[1:0]};
      if (entry_we_i) begin
        entry_q.periodic <= wdata_i[PER_BIT];
        entry_q.masked   <= wdata_i[MASK_BIT];
        entry_q.vec      <= wdata_i[VEC_W-1:0];
      end
      if (init_we_i)  init_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign div_cfg_o = div_q;
  assign entry_o   = entry_q;
  assign init_o    = init_q;
  assign shift_o   = div_to_shift(div_q);
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int unsigned PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign low_mask[i] = (32'(shift_i) > i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end

  // tick when the low shift bits are all ones
  assign tick_o = &(pre_q | ~low_mask);
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             entry_we_i,
  input  entry_t           entry_i,
  output logic [CNT_W-1:0] count_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             event_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= 1'b0;
      if (load_i) begin
        cnt_q   <= load_val_i;
        armed_q <= (load_val_i != '0);
      end else begin
        if (tick_i) begin
          if (!at_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (entry_i.periodic) begin
            cnt_q   <= reload_i;
            armed_q <= 1'b0;
            event_q <= (reload_i != '0) && !entry_i.masked;
          end else if (armed_q) begin
            armed_q <= 1'b0;
            event_q <= !entry_i.masked;
          end
        end
        // expiry already reached: an entry rewrite drops it
        if (entry_we_i && at_zero) armed_q <= 1'b0;
      end
    end
  end

  assign count_o = cnt_q;
  assign event_o = event_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic              entry_we_i,
  input  logic              init_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] div_cfg_o,
  output logic [DATA_W-1:0] entry_o,
  output logic [DATA_W-1:0] cur_count_o,
  output logic              event_o,
  output logic [VEC_W-1:0]  vector_o
);
  localparam int unsigned CNT_W = DATA_W;

  logic [DIV_W-1:0]   div_cfg;
  entry_t             entry;
  logic [CNT_W-1:0]   init_val;
  logic [SHIFT_W-1:0] shift;
  logic               tick;

  tick_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_we_i   (div_we_i),
    .entry_we_i (entry_we_i),
    .init_we_i  (init_we_i),
    .wdata_i    (wdata_i),
    .div_cfg_o  (div_cfg),
    .entry_o    (entry),
    .init_o     (init_val),
    .shift_o    (shift)
  );

  tick_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (init_we_i),
    .shift_i (shift),
    .tick_o  (tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (init_we_i),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .reload_i   (init_val),
    .entry_we_i (entry_we_i),
    .entry_i    (entry),
    .count_o    (cur_count_o),
    .event_o    (event_o)
  );

  always_comb begin
    div_cfg_o                = '0;
    div_cfg_o[DIV_W-1:0]     = div_cfg;
    entry_o                  = '0;
    entry_o[VEC_W-1:0]       = entry.vec;
    entry_o[MASK_BIT]        = entry.masked;
    entry_o[PER_BIT]         = entry.periodic;
  end

  assign vector_o = entry.vec;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] entry_o,
  input logic [DATA_W-1:0] cur_count_o,
  input logic              event_o
);
  // R10
  event_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  // R5
  event_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> ($past(cur_count_o) == '0));

  // R7
  event_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> !$past(entry_o[MASK_BIT]));

  // R4
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_we_i |=> (cur_count_o == $past(wdata_i)));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!entry_o[PER_BIT] && (cur_count_o == '0) && !init_we_i) |=> (cur_count_o == '0));

  // R6
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && $past(entry_o[PER_BIT])) |-> (cur_count_o != '0));
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_we_i   (init_we_i),
  .wdata_i     (wdata_i),
  .entry_o     (entry_o),
  .cur_count_o (cur_count_o),
  .event_o     (event_o)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_we = 1'b0, entry_we = 1'b0, init_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] div_cfg, entry, cur;
  logic        evt;
  logic [7:0]  vec;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .entry_we_i(entry_we),
    .init_we_i(init_we), .wdata_i(wdata), .div_cfg_o(div_cfg), .entry_o(entry),
    .cur_count_o(cur), .event_o(evt), .vector_o(vec)
  );

  // behavioural reference
  logic [31:0] m_cnt, m_init, m_entry, m_div;
  int          m_pre;
  bit          m_armed, m_evt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_init = 0; m_entry = 32'h10000; m_div = 0;
      m_pre = 0; m_armed = 0; m_evt = 0;
    end else begin
      int sh;
      bit tk;
      logic [31:0] old_cnt;
      sh = ({m_div[3], m_div[1:0]} + 1) % 8;
      tk = ((m_pre + 1) % (1 << sh)) == 0;
      old_cnt = m_cnt;
      m_evt = 0;
      if (init_we) begin
        m_cnt = wdata; m_armed = (wdata != 0); m_pre = 0;
      end else begin
        m_pre = (m_pre + 1) % 128;
        if (tk) begin
          if (m_cnt != 0) m_cnt = m_cnt - 1;
          else if (m_entry[17]) begin
            m_cnt = m_init; m_armed = 0; m_evt = (m_init != 0) && !m_entry[16];
          end else if (m_armed) begin
            m_armed = 0; m_evt = !m_entry[16];
          end
        end
        if (entry_we && old_cnt == 0) m_armed = 0;
      end
      if (init_we)  m_init  = wdata;
      if (div_we)   m_div   = wdata & 32'hB;
      if (entry_we) m_entry = wdata & 32'h300FF;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur == m_cnt, "R4 count", cur, m_cnt);
    chk(evt == m_evt, "R5 event", evt, m_evt);
    chk(vec == m_entry[7:0], "R10 vector", vec, m_entry[7:0]);
    chk(entry == m_entry, "R3 entry", entry, m_entry);
    chk(div_cfg == m_div, "R1 divcfg", div_cfg, m_div);
  end

  task automatic wr(input int which, input logic [31:0] v);
    wdata = v;
    div_we = (which == 0); entry_we = (which == 1); init_we = (which == 2);
    @(negedge clk);
    div_we = 0; entry_we = 0; init_we = 0;
  endtask

  task automatic count_ev(input int n, output int k);
    k = 0;
    repeat (n) begin @(negedge clk); if (evt) k++; end
  endtask

  bit done = 0;

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk(entry == 32'h10000, "R9 entry", entry, 32'h10000);
    chk(cur == 0, "R9 count", cur, 0);
    chk(div_cfg == 0, "R9 divcfg", div_cfg, 0);
    chk(evt == 0, "R9 event", evt, 0);
    // R1 masking
    wr(0, 32'hFFFF_FFFF);
    chk(div_cfg == 32'hB, "R1 divcfg mask", div_cfg, 32'hB);
    // R3 fields
    wr(1, 32'hFFFF_FF3C);
    chk(entry == 32'h3003C, "R3 entry fields", entry, 32'h3003C);
    // R5 one-shot, divide by 1
    wr(1, 32'h41);
    wr(2, 5);
    chk(cur == 5, "R4 load", cur, 5);
    count_ev(20, k);
    chk(k == 1, "R5 single event", k, 1);
    chk(cur == 0, "R5 saturate", cur, 0);
    wr(2, 0);
    count_ev(10, k);
    chk(k == 0, "R5 zero load", k, 0);
    // R6 periodic
    wr(1, 32'h20042);
    wr(2, 3);
    count_ev(40, k);
    chk(k == 10, "R6 period events", k, 10);
    wr(2, 0);
    count_ev(20, k);
    chk(k == 0, "R6 zero load", k, 0);
    chk(cur == 0, "R6 zero count", cur, 0);
    // R2 divide by 2
    wr(1, 32'h41);
    wr(0, 0);
    wr(2, 2);
    @(negedge clk);
    chk(cur == 2, "R2 div2 hold", cur, 2);
    @(negedge clk);
    chk(cur == 1, "R2 div2 step", cur, 1);
    // R2 code 3 -> divide by 16
    wr(0, 3);
    wr(2, 1);
    repeat (15) @(negedge clk);
    chk(cur == 1, "R2 div16 hold", cur, 1);
    @(negedge clk);
    chk(cur == 0, "R2 div16 step", cur, 0);
    // R7 masked expiry consumed
    wr(0, 32'hB);
    wr(1, 32'h10041);
    wr(2, 2);
    count_ev(10, k);
    chk(k == 0, "R7 masked", k, 0);
    chk(cur == 0, "R7 count runs", cur, 0);
    wr(1, 32'h41);
    count_ev(10, k);
    chk(k == 0, "R7 consumed", k, 0);
    // R8 entry write at zero cancels
    wr(0, 0);
    wr(2, 1);
    @(negedge clk);
    @(negedge clk);
    chk(cur == 0, "R8 at zero", cur, 0);
    wr(1, 32'h55);
    count_ev(10, k);
    chk(k == 0, "R8 cancelled", k, 0);
    // R11 load on tick edge
    wr(0, 32'hB);
    wr(2, 1);
    @(negedge clk);
    wr(2, 7);
    chk(evt == 0, "R11 no event", evt, 0);
    chk(cur == 7, "R11 loaded", cur, 7);
    count_ev(12, k);
    chk(k == 1, "R10 later event", k, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule